// File: doc/BRIEF.md
# Two-Stage Seconds Tick Divider

This block turns a slow real-time reference clock into a one-second tick through two programmable divide-by-(N+1) stages in cascade. The first stage counts reference cycles down from a 7-bit reload value. Each time it wraps, it emits a single-cycle intermediate enable. That enable steps a 15-bit subsecond down-counter. The subsecond counter's live value is visible on a port. When it wraps from zero back to its 15-bit reload value, it emits the seconds tick. With a first-stage factor of 128 and a second-stage factor of 256, a 32.768 kHz reference gives exactly one tick per second. The overall factor runs from 1 up to 2^22.

Both ticks are one-cycle enable pulses in the reference clock domain. They are never derived clocks. A select input routes either tick to a timebase output, which feeds a downstream calendar or a wakeup auto-reload timer.

A small control state machine gates the counters and has two states:
- **HOLD** is entered on reset. It loads both counters from their reload inputs on every cycle.
- **RUN** makes both counters count.

It has two transitions:
- **HOLD→RUN** is taken on the first edge at which the enable is sampled high. That edge is an arming edge, so the counters are loaded once more.
- **RUN→HOLD** is taken on any edge at which the enable is sampled low. At that edge the counters are reloaded.

Top module: `rtc_tick_divider`

## Requirements
- R1: While reset is asserted, and on the cycle after it, both ticks are 0 and the subsecond count equals the 15-bit second-stage reload value.
- R2: While the enable is low, the subsecond count follows the second-stage reload value and neither tick is asserted.
- R3: In steady counting with first-stage reload A, the intermediate enable is a one-cycle pulse that repeats every A+1 clock cycles.
- R4: On each intermediate enable cycle that is not a seconds tick, the subsecond count is one less than on the cycle before.
- R5: The seconds tick is asserted exactly on the cycle in which the subsecond count changes from 0 to the second-stage reload value, and only together with the intermediate enable.
- R6: If the enable is first sampled high at edge e0, the first intermediate enable appears after edge e(A+1). The first seconds tick appears after edge e((A+1)(S+1)), and the tick then repeats every (A+1)(S+1) cycles, where S is the second-stage reload.
- R7: With both reload values 0, the overall factor is 1, and both ticks are asserted on every cycle after the arming edge.
- R8: The timebase output equals the intermediate enable when the select input is 1, and the seconds tick when it is 0.
- R9: A change to the second-stage reload value during counting does not alter the subsecond count in progress. It takes effect at the next wrap from 0.
- R10: With reload values 127 and 255, the seconds tick repeats every 32768 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Count enable; low holds both counters at their reload values |
| async_div | input | 7 | First-stage reload A (divide by A+1) |
| sync_div | input | 15 | Second-stage reload S (divide by S+1) |
| tick_sel | input | 1 | 1 routes the intermediate enable to timebase_tick, 0 routes the seconds tick |
| async_tick | output | 1 | One-cycle intermediate enable pulse |
| sec_tick | output | 1 | One-cycle seconds tick pulse |
| subsec_count | output | 15 | Live subsecond down-counter value |
| timebase_tick | output | 1 | Selected tick for a calendar or wakeup timer |

## Verification
The assertions check the following on every cycle:
- the seconds tick never appears without the intermediate enable;
- every seconds tick coincides with a reload from zero to the programmed value;
- each non-wrapping intermediate enable lowers the subsecond count by exactly one;
- a low enable forces the reload value and silences both ticks.

Other behaviours need the bench's scenarios, which compare exact tick cycles and subsecond values against a queue of predicted events:
- the absolute periods and the arming delay after the enable rises;
- the divide-by-one case;
- the 1 Hz configuration;
- the deferred effect of a reload value changed mid-count.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    // Control modes of the divider
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/rtc_div_ctrl.sv
module rtc_div_ctrl
    import rtc_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic load_o,
    output logic step_o
);

    div_state_e state_q;
    div_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = run_en ? ST_RUN : ST_HOLD;
            ST_RUN:  state_d = run_en ? ST_RUN : ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs: the arming edge in HOLD still loads
    always_comb begin
        load_o = 1'b1;
        step_o = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                load_o = 1'b1;
                step_o = 1'b0;
            end
            ST_RUN: begin
                load_o = !run_en;
                step_o = run_en;
            end
            default: begin
                load_o = 1'b1;
                step_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt_o  <= reload;
            wrap_o <= 1'b0;
        end else if (step) begin
            if (cnt_o == ZERO) begin
                cnt_o  <= reload;
                wrap_o <= 1'b1;
            end else begin
                cnt_o  <= cnt_o - ONE;
                wrap_o <= 1'b0;
            end
        end else begin
            wrap_o <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
    parameter int A_W = 7,
    parameter int S_W = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic [A_W-1:0] async_div,
    input  logic [S_W-1:0] sync_div,
    input  logic           tick_sel,
    output logic           async_tick,
    output logic           sec_tick,
    output logic [S_W-1:0] subsec_count,
    output logic           timebase_tick
);

    localparam logic [A_W-1:0] A_ZERO = '0;

    logic           load;
    logic           step;
    logic [A_W-1:0] a_cnt;
    logic           a_step;

    rtc_div_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .load_o (load),
        .step_o (step)
    );

    rtc_div_stage #(.W(A_W)) u_stage_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .reload (async_div),
        .cnt_o  (a_cnt),
        .wrap_o (async_tick)
    );

    // The second stage advances on the edge where the first stage wraps
    assign a_step = step && (a_cnt == A_ZERO);

    rtc_div_stage #(.W(S_W)) u_stage_s (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (a_step),
        .reload (sync_div),
        .cnt_o  (subsec_count),
        .wrap_o (sec_tick)
    );

    assign timebase_tick = tick_sel ? async_tick : sec_tick;

endmodule

// File: rtl/rtc_tick_divider_chk.sv
module rtc_tick_divider_chk #(
    parameter int S_W = 15
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run_en,
    input logic [S_W-1:0] sync_div,
    input logic           async_tick,
    input logic           sec_tick,
    input logic [S_W-1:0] subsec_count
);

    p_sec_with_async_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> async_tick);

    p_reload_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (subsec_count == $past(sync_div)) && ($past(subsec_count) == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!async_tick && !sec_tick && subsec_count == $past(sync_div)));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (async_tick && !sec_tick) |-> (subsec_count == $past(subsec_count) - S_W'(1)));

endmodule

bind rtc_tick_divider rtc_tick_divider_chk #(.S_W(S_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .sync_div     (sync_div),
    .async_tick   (async_tick),
    .sec_tick     (sec_tick),
    .subsec_count (subsec_count)
);

// File: tb/tb_rtc_tick_divider.sv
`timescale 1ns/1ps
module tb_rtc_tick_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [6:0]  async_div = '0;
    logic [14:0] sync_div = '0;
    logic        tick_sel = 1'b0;
    logic        async_tick;
    logic        sec_tick;
    logic [14:0] subsec_count;
    logic        timebase_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit sb_on  = 1'b0;
    bit done   = 1'b0;

    typedef struct {
        int at;
        int sub;
    } aexp_t;

    aexp_t aq[$];
    int    sq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_tick_divider dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .async_div     (async_div),
        .sync_div      (sync_div),
        .tick_sel      (tick_sel),
        .async_tick    (async_tick),
        .sec_tick      (sec_tick),
        .subsec_count  (subsec_count),
        .timebase_tick (timebase_tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops predicted events as the design produces ticks
    always @(negedge clk) begin
        if (sb_on && rst_n) begin
            chk(timebase_tick == (tick_sel ? async_tick : sec_tick), "R8",
                "timebase select", int'(timebase_tick),
                int'(tick_sel ? async_tick : sec_tick));
            if (async_tick) begin
                if (aq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected intermediate enable at cycle", cyc, -1);
                end else begin
                    aexp_t e;
                    e = aq.pop_front();
                    chk(cyc == e.at, "R3", "intermediate enable cycle", cyc, e.at);
                    chk(int'(subsec_count) == e.sub, "R4", "subsecond value", int'(subsec_count), e.sub);
                end
            end
            if (sec_tick) begin
                if (sq.size() == 0) begin
                    chk(1'b0, "R6", "unexpected seconds tick at cycle", cyc, -1);
                end else begin
                    int t;
                    t = sq.pop_front();
                    chk(cyc == t, "R6", "seconds tick cycle", cyc, t);
                    chk(subsec_count == sync_div, "R5", "reload on tick",
                        int'(subsec_count), int'(sync_div));
                end
            end
        end
    end

    // Driver: programs a configuration and predicts every tick
    task automatic run_cfg(input int a, input int s, input int nsec, input bit sel, input string req);
        int base;
        int p;
        @(negedge clk);
        run_en    = 1'b0;
        async_div = 7'(a);
        sync_div  = 15'(s);
        tick_sel  = sel;
        repeat (2) @(negedge clk);
        base = cyc;
        p = (a + 1) * (s + 1);
        for (int j = 1; j <= nsec * (s + 1); j++) begin
            aexp_t e;
            e.at  = base + 1 + j * (a + 1);
            e.sub = s - (j % (s + 1));
            aq.push_back(e);
        end
        for (int k = 1; k <= nsec; k++) sq.push_back(base + 1 + k * p);
        sb_on  = 1'b1;
        run_en = 1'b1;
        repeat (nsec * p + 1) @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(aq.size() == 0, req, "intermediate events left", aq.size(), 0);
        chk(sq.size() == 0, req, "seconds events left", sq.size(), 0);
        sb_on = 1'b0;
        aq.delete();
        sq.delete();
    endtask

    initial begin
        // R1: reset state
        async_div = 7'd2;
        sync_div  = 15'd5;
        repeat (3) @(negedge clk);
        chk(subsec_count == 15'd5, "R1", "subsec in reset", int'(subsec_count), 5);
        chk(!async_tick && !sec_tick, "R1", "ticks in reset", int'({async_tick, sec_tick}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(subsec_count == 15'd5, "R1", "subsec after reset", int'(subsec_count), 5);
        chk(!async_tick && !sec_tick, "R1", "ticks after reset", int'({async_tick, sec_tick}), 0);

        // R2: held while disabled, reload tracked
        sync_div  = 15'd9;
        async_div = 7'd0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(subsec_count == 15'd9, "R2", "subsec held", int'(subsec_count), 9);
            chk(!async_tick && !sec_tick, "R2", "no ticks held", int'({async_tick, sec_tick}), 0);
        end

        // R9: reload change mid-count applies at next wrap
        sync_div = 15'd3;
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        chk(subsec_count == 15'd3, "R9", "after arming edge", int'(subsec_count), 3);
        @(negedge clk);
        chk(subsec_count == 15'd2, "R9", "first step", int'(subsec_count), 2);
        sync_div = 15'd1;
        @(negedge clk);
        chk(subsec_count == 15'd1, "R9", "count unaffected by new reload", int'(subsec_count), 1);
        @(negedge clk);
        chk(subsec_count == 15'd0, "R9", "reaches zero", int'(subsec_count), 0);
        @(negedge clk);
        chk(subsec_count == 15'd1 && sec_tick, "R9", "reload uses new value",
            int'(subsec_count), 1);
        run_en = 1'b0;
        @(negedge clk);

        // R3 R4 R5 R6 R8: scoreboard runs
        run_cfg(2, 3, 3, 1'b1, "R6");
        run_cfg(5, 1, 4, 1'b0, "R6");
        // R7: divide by one
        run_cfg(0, 0, 6, 1'b1, "R7");
        // R10: one-second configuration
        run_cfg(127, 255, 2, 1'b0, "R10");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule